// File: doc/BRIEF.md
# Dual-Bank Image Validator

The block reads two configuration images stored back to back in a pair of flash banks and decides which one the system should use. It fetches bytes one at a time through a valid/ready read port. For each bank it checks three things: a fixed signature byte, an 8-bit header sum that wraps its carries back into the low bits, and a 32-bit running checksum over the image body, reduced modulo 65521. When both banks have been read, it reports which bank is valid and the generation number of each. The active bank is the valid bank with the larger generation.

A second mode, sealing, prepares an image before it is written back. The block streams one image and returns the values to place in its header. These are the next generation number, the header sum recomputed with the correct signature, and the body checksum computed with the new generation already in place. It also names the bank to write, which is always the bank that is currently not active. The flash command protocol and the storage itself lie outside the block.

Top module: `nv_bank_validator`

## Requirements
- R1: A scan presents `addr_o` = 0, 1, …, 2·IMG_BYTES−1 in ascending order, and a seal presents 0 … IMG_BYTES−1. The address advances by one only on a cycle where `valid_i` and `ready_o` are both high, and otherwise holds. `ready_o` is low whenever no operation is running.
- R2: A bank is valid only when its image byte at offset 0 equals 0x5A.
- R3: The header sum is stored at offset 1. It is computed by starting from the offset-0 byte and adding the bytes at offsets 2 through 15. While the sum exceeds 255, it is replaced by (sum mod 256) + (sum div 256). A bank is valid only when the stored byte equals this result.
- R4: The body checksum runs over the bytes from offset 0x14 to the end of the image. It keeps two sums: a low sum starting at 1 and a high sum starting at 0. For each byte, the byte is added to the low sum, and then the new low sum is added to the high sum. Both sums are reduced mod 65521. The result is packed as {high[15:0], low[15:0]} and must equal the big-endian word at offsets 0x10–0x13.
- R5: The generation is the big-endian word at offsets 0x18–0x1B. `gen0_o`/`gen1_o` report it for a valid bank and report 0 for an invalid bank. `bank_ok_o[b]` flags bank b as valid.
- R6: `active_o` is 1 exactly when the reported generation of bank 0 is strictly less than that of bank 1. In every other case, including equal generations, it is 0.
- R7: After reset, all result outputs, `busy_o` and `done_o` are 0. Each operation ends with a one-cycle `done_o` pulse. The results then hold until the next operation writes them.
- R8: A seal reports `seal_gen_o` = generation + 1 (mod 2^32). It reports `seal_cksum_o` computed as in R3 but with 0x5A in place of the offset-0 byte. It reports `seal_adler_o` computed as in R4 with the incremented generation substituted at offsets 0x18–0x1B. A seal leaves `bank_ok_o`, `active_o` and the generation outputs unchanged.
- R9: `seal_bank_o` names the bank that is not active, as set by the last scan.
- R10: `start_i` has no effect while an operation is running: no second operation starts and no second `done_o` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when idle |
| seal_i | input | 1 | Operation type sampled with start: 0 scan, 1 seal |
| data_i | input | 8 | Byte read from `addr_o` |
| valid_i | input | 1 | `data_i` holds the byte at `addr_o` |
| ready_o | output | 1 | Block accepts a byte this cycle |
| addr_o | output | AW | Byte address requested (bank in MSB) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| active_o | output | 1 | Selected bank |
| bank_ok_o | output | 2 | Per-bank valid flags |
| gen0_o | output | 32 | Bank 0 generation (0 if invalid) |
| gen1_o | output | 32 | Bank 1 generation (0 if invalid) |
| seal_bank_o | output | 1 | Bank to write the sealed image into |
| seal_gen_o | output | 32 | Incremented generation for the sealed image |
| seal_cksum_o | output | 8 | Header sum for the sealed image |
| seal_adler_o | output | 32 | Body checksum for the sealed image |

## Verification
The hardest case to reach is the seal of an image whose generation carries across byte boundaries. The incremented value then differs from the streamed bytes in several positions, and the body checksum must see the new bytes in their original order. The bench seals images with generations 0xFF, 0xFFFFFFFF and an arbitrary mid value, each with a wrong signature byte, and compares the results against checksums it computes on a copy with the generation bumped. The bench also uses a 512-byte image filled with 0xFF so the low sum wraps the modulus, and it injects signature, header and body faults into each bank independently.

// File: rtl/nv_pkg.sv
package nv_pkg;
  localparam logic [7:0]  SIG_BYTE  = 8'h5A;
  localparam logic [16:0] ADL_MOD   = 17'd65521;
  // fixed header layout (offsets matter: neighbours decode these fields)
  localparam int unsigned OFS_CK    = 1;
  localparam int unsigned OFS_HLO   = 2;
  localparam int unsigned OFS_HHI   = 15;
  localparam int unsigned OFS_ADL   = 16;
  localparam int unsigned OFS_ADL_E = 19;
  localparam int unsigned OFS_BODY  = 20;
  localparam int unsigned OFS_GEN   = 24;
  localparam int unsigned OFS_GEN_E = 27;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FOLD, ST_EVAL} nv_state_e;
endpackage

// File: rtl/nv_addr_gen.sv
module nv_addr_gen #(
  parameter int unsigned IMG_BYTES = 8192,
  localparam int unsigned IW = $clog2(IMG_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic          next_bank_i,
  output logic [IW-1:0] idx_o,
  output logic          bank_o,
  output logic          last_o
);
  logic [IW-1:0] idx_q;
  logic          bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      bank_q <= 1'b0;
    end else if (clr_i) begin
      idx_q  <= '0;
      bank_q <= 1'b0;
    end else if (next_bank_i) begin
      idx_q  <= '0;
      bank_q <= 1'b1;
    end else if (step_i) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign bank_o = bank_q;
  assign last_o = (idx_q == IW'(IMG_BYTES - 1));
endmodule

// File: rtl/nv_hdr_sum.sv
module nv_hdr_sum (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic [7:0] init_val_i,
  input  logic       en_i,
  input  logic [7:0] byte_i,
  output logic [7:0] sum_o
);
  logic [7:0] acc_q;
  logic [8:0] raw;
  logic [7:0] folded;

  // end-around carry per byte: same residue and range as a final fold
  always_comb begin
    raw    = {1'b0, acc_q} + {1'b0, byte_i};
    folded = raw[7:0] + {7'd0, raw[8]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (init_i) acc_q <= init_val_i;
    else if (en_i)   acc_q <= folded;
  end

  assign sum_o = acc_q;
endmodule

// File: rtl/nv_adler.sv
module nv_adler
  import nv_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] sum_o
);
  logic [15:0] lo_q, hi_q, lo_n, hi_n;
  logic [16:0] lo_s, hi_s;

  always_comb begin
    lo_s = {1'b0, lo_q} + {9'd0, byte_i};
    lo_n = (lo_s >= ADL_MOD) ? 16'(lo_s - ADL_MOD) : lo_s[15:0];
    hi_s = {1'b0, hi_q} + {1'b0, lo_n};
    hi_n = (hi_s >= ADL_MOD) ? 16'(hi_s - ADL_MOD) : hi_s[15:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= 16'd1;
      hi_q <= 16'd0;
    end else if (clr_i) begin
      lo_q <= 16'd1;
      hi_q <= 16'd0;
    end else if (en_i) begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign sum_o = {hi_q, lo_q};
endmodule

// File: rtl/nv_bank_validator.sv
module nv_bank_validator
  import nv_pkg::*;
#(
  parameter int unsigned IMG_BYTES = 8192,
  localparam int unsigned AW = $clog2(2 * IMG_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          seal_i,
  input  logic [7:0]    data_i,
  input  logic          valid_i,
  output logic          ready_o,
  output logic [AW-1:0] addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          active_o,
  output logic [1:0]    bank_ok_o,
  output logic [31:0]   gen0_o,
  output logic [31:0]   gen1_o,
  output logic          seal_bank_o,
  output logic [31:0]   seal_gen_o,
  output logic [7:0]    seal_cksum_o,
  output logic [31:0]   seal_adler_o
);
  localparam int unsigned IW = AW - 1;
  localparam logic [IW-1:0] I_CK    = IW'(OFS_CK);
  localparam logic [IW-1:0] I_HLO   = IW'(OFS_HLO);
  localparam logic [IW-1:0] I_HHI   = IW'(OFS_HHI);
  localparam logic [IW-1:0] I_ADL   = IW'(OFS_ADL);
  localparam logic [IW-1:0] I_ADL_E = IW'(OFS_ADL_E);
  localparam logic [IW-1:0] I_BODY  = IW'(OFS_BODY);
  localparam logic [IW-1:0] I_GEN   = IW'(OFS_GEN);
  localparam logic [IW-1:0] I_GEN_E = IW'(OFS_GEN_E);

  nv_state_e     st_q;
  logic          seal_q, done_q, active_q;
  logic [1:0]    fold_q;
  logic [7:0]    sig_q, ck_q;
  logic [31:0]   adl_q, gen_q;
  logic          ok_r  [2];
  logic [31:0]   gen_r [2];
  logic [31:0]   sgen_q, sadl_q;
  logic [7:0]    sck_q;

  logic [IW-1:0] idx;
  logic          bank, last;
  logic          accept, launch, next_bank, eval_scan;
  logic          in_gen, in_adl, hdr_en, adl_en;
  logic [7:0]    hdr_sum, adl_byte, fold_byte;
  logic [31:0]   adl_sum, gen_adj, bank_gen;
  logic          bank_ok;

  assign ready_o   = (st_q == ST_RUN);
  assign busy_o    = (st_q != ST_IDLE);
  assign accept    = ready_o && valid_i;
  assign launch    = (st_q == ST_IDLE) && start_i;
  assign next_bank = (st_q == ST_EVAL) && !seal_q && !bank;
  assign eval_scan = (st_q == ST_EVAL) && !seal_q;

  assign in_gen = (idx >= I_GEN) && (idx <= I_GEN_E);
  assign in_adl = (idx >= I_ADL) && (idx <= I_ADL_E);
  assign hdr_en = accept && (idx >= I_HLO) && (idx <= I_HHI);
  // generation bytes are deferred and folded in after capture (they may change on seal)
  assign adl_en = (accept && (idx >= I_BODY) && !in_gen) || (st_q == ST_FOLD);

  assign gen_adj = gen_q + {31'd0, seal_q};
  always_comb begin
    unique case (fold_q)
      2'd0:    fold_byte = gen_adj[31:24];
      2'd1:    fold_byte = gen_adj[23:16];
      2'd2:    fold_byte = gen_adj[15:8];
      default: fold_byte = gen_adj[7:0];
    endcase
  end
  assign adl_byte = (st_q == ST_FOLD) ? fold_byte : data_i;

  nv_addr_gen #(.IMG_BYTES(IMG_BYTES)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (launch),
    .step_i      (accept),
    .next_bank_i (next_bank),
    .idx_o       (idx),
    .bank_o      (bank),
    .last_o      (last)
  );

  nv_hdr_sum u_hdr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (accept && (idx == '0)),
    .init_val_i (seal_q ? SIG_BYTE : data_i),
    .en_i       (hdr_en),
    .byte_i     (data_i),
    .sum_o      (hdr_sum)
  );

  nv_adler u_adl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (launch || next_bank),
    .en_i   (adl_en),
    .byte_i (adl_byte),
    .sum_o  (adl_sum)
  );

  assign bank_ok  = (sig_q == SIG_BYTE) && (ck_q == hdr_sum) && (adl_q == adl_sum);
  assign bank_gen = bank_ok ? gen_q : 32'd0;

  // field capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q <= '0;
      ck_q  <= '0;
      adl_q <= '0;
      gen_q <= '0;
    end else if (accept) begin
      if (idx == '0)  sig_q <= data_i;
      if (idx == I_CK) ck_q <= data_i;
      if (in_adl)     adl_q <= {adl_q[23:0], data_i};
      if (in_gen)     gen_q <= {gen_q[23:0], data_i};
    end
  end

  // sequencing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      seal_q <= 1'b0;
      fold_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          seal_q <= seal_i;
          st_q   <= ST_RUN;
        end
        ST_RUN: if (accept) begin
          if (idx == I_GEN_E) begin
            st_q   <= ST_FOLD;
            fold_q <= '0;
          end else if (last) begin
            st_q <= ST_EVAL;
          end
        end
        ST_FOLD: begin
          fold_q <= fold_q + 2'd1;
          if (fold_q == 2'd3) st_q <= ST_RUN;
        end
        default: begin
          if (next_bank) st_q <= ST_RUN;
          else begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
      endcase
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ok_r[b]  <= 1'b0;
        gen_r[b] <= '0;
      end else if (eval_scan && (bank == 1'(b))) begin
        ok_r[b]  <= bank_ok;
        gen_r[b] <= bank_gen;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sgen_q   <= '0;
      sck_q    <= '0;
      sadl_q   <= '0;
    end else if (st_q == ST_EVAL) begin
      if (!seal_q && bank) active_q <= (gen_r[0] < bank_gen);
      if (seal_q) begin
        sgen_q <= gen_adj;
        sck_q  <= hdr_sum;
        sadl_q <= adl_sum;
      end
    end
  end

  assign addr_o       = {bank, idx};
  assign done_o       = done_q;
  assign active_o     = active_q;
  assign bank_ok_o    = {ok_r[1], ok_r[0]};
  assign gen0_o       = gen_r[0];
  assign gen1_o       = gen_r[1];
  assign seal_bank_o  = ~active_q;
  assign seal_gen_o   = sgen_q;
  assign seal_cksum_o = sck_q;
  assign seal_adler_o = sadl_q;
endmodule

// File: rtl/nv_bank_validator_chk.sv
module nv_bank_validator_chk #(
  parameter int unsigned IMG_BYTES = 8192,
  localparam int unsigned AW = $clog2(2 * IMG_BYTES)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          ready_o,
  input logic [AW-1:0] addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          active_o,
  input logic [1:0]    bank_ok_o,
  input logic [31:0]   gen0_o,
  input logic [31:0]   gen1_o
);
  // R1
  rdy_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> busy_o);
  // R1
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !valid_i) |=> $stable(addr_o));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R5
  bad0_gen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_ok_o[0] |-> (gen0_o == 32'd0));
  // R5
  bad1_gen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_ok_o[1] |-> (gen1_o == 32'd0));
  // R6
  active_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (active_o == (gen0_o < gen1_o)));
endmodule

bind nv_bank_validator nv_bank_validator_chk #(.IMG_BYTES(IMG_BYTES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .ready_o   (ready_o),
  .addr_o    (addr_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .active_o  (active_o),
  .bank_ok_o (bank_ok_o),
  .gen0_o    (gen0_o),
  .gen1_o    (gen1_o)
);

// File: tb/nv_bank_validator_bench.sv
module nv_bank_validator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IMG = 512;
  localparam int AW  = $clog2(2 * IMG);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0, seal_i = 1'b0, valid_i = 1'b0;
  logic [7:0]    data_i = '0;
  logic          ready_o, busy_o, done_o, active_o, seal_bank_o;
  logic [AW-1:0] addr_o;
  logic [1:0]    bank_ok_o;
  logic [31:0]   gen0_o, gen1_o, seal_gen_o, seal_adler_o;
  logic [7:0]    seal_cksum_o;

  logic [7:0] mem [0:2*IMG-1];
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nv_bank_validator #(.IMG_BYTES(IMG)) u_nv_bank_validator (
    .clk_i, .rst_ni, .start_i, .seal_i, .data_i, .valid_i, .ready_o, .addr_o,
    .busy_o, .done_o, .active_o, .bank_ok_o, .gen0_o, .gen1_o, .seal_bank_o,
    .seal_gen_o, .seal_cksum_o, .seal_adler_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] calc_ck(input int base, input logic [7:0] sig);
    int s = sig;
    for (int i = 2; i <= 15; i++) s += mem[base+i];
    while (s > 255) s = (s & 255) + (s >> 8);
    return 8'(s);
  endfunction

  function automatic logic [31:0] calc_adl(input int base);
    longint lo = 1, hi = 0;
    for (int i = 20; i < IMG; i++) begin
      lo += mem[base+i];
      hi += lo;
    end
    return 32'(((hi % 65521) << 16) | (lo % 65521));
  endfunction

  task automatic put32(input int a, input logic [31:0] v);
    mem[a] = v[31:24]; mem[a+1] = v[23:16]; mem[a+2] = v[15:8]; mem[a+3] = v[7:0];
  endtask

  // damage: 0 none, 1 signature, 2 header sum, 3 body byte
  task automatic build(input int bk, input logic [31:0] gen, input int seed, input int dmg);
    int base = bk * IMG;
    logic [31:0] a;
    for (int i = 0; i < IMG; i++)
      mem[base+i] = (seed == 0) ? 8'hFF : 8'((i * seed + (i >> 4)) & 255);
    mem[base] = 8'h5A;
    mem[base+2] = 8'h00;
    mem[base+3] = 8'(IMG / 16);
    for (int i = 4; i <= 15; i++) mem[base+i] = 8'(8'hE0 + i + seed);
    put32(base+24, gen);
    put32(base+28, 32'd0);
    put32(base+32, 32'd0);
    mem[base+1] = calc_ck(base, 8'h5A);
    a = calc_adl(base);
    put32(base+16, a);
    if (dmg == 1) mem[base] = 8'hA5;
    if (dmg == 2) mem[base+1] = mem[base+1] ^ 8'h01;
    if (dmg == 3) mem[base+IMG-1] = mem[base+IMG-1] ^ 8'h40;
  endtask

  // streams one operation; poke injects a start while busy (R10)
  task automatic run_op(input bit seal, input bit poke, input int exp_n);
    int acc = 0, aerr = 0, cyc = 0, extra = 0;
    @(negedge clk_i); start_i = 1'b1; seal_i = seal;
    @(negedge clk_i); start_i = 1'b0; seal_i = 1'b0;
    while (!done_o && cyc < 20000) begin
      valid_i = ((cyc % 5) != 3);
      data_i  = mem[int'(addr_o)];
      if (valid_i && ready_o) begin
        if (int'(addr_o) != acc) aerr++;
        acc++;
      end
      if (poke && cyc == 40) begin start_i = 1'b1; seal_i = ~seal; end
      else begin start_i = 1'b0; seal_i = 1'b0; end
      cyc++;
      @(negedge clk_i);
    end
    valid_i = 1'b0; start_i = 1'b0;
    chk(done_o == 1'b1, "R7 done seen", 32'(done_o), 1);
    chk(aerr == 0 && acc == exp_n, "R1 address order/count", 32'(acc), 32'(exp_n));
    @(negedge clk_i);
    chk(!done_o && !ready_o && !busy_o, "R7 single done pulse, idle", {busy_o, ready_o, done_o}, 0);
    if (poke) begin
      for (int k = 0; k < 20; k++) begin
        @(negedge clk_i);
        if (done_o || busy_o) extra++;
      end
      chk(extra == 0, "R10 start while busy ignored", 32'(extra), 0);
    end
  endtask

  task automatic scan_check(input bit ok0, input bit ok1, input logic [31:0] g0,
                            input logic [31:0] g1, input bit poke, input string tag);
    logic [31:0] e0 = ok0 ? g0 : 32'd0;
    logic [31:0] e1 = ok1 ? g1 : 32'd0;
    logic        ea = (e0 < e1);
    run_op(1'b0, poke, 2 * IMG);
    chk(bank_ok_o == {ok1, ok0}, {tag, " R2 R3 R4 valid flags"}, 32'(bank_ok_o), 32'({ok1, ok0}));
    chk(gen0_o == e0, {tag, " R5 gen0"}, gen0_o, e0);
    chk(gen1_o == e1, {tag, " R5 gen1"}, gen1_o, e1);
    chk(active_o == ea, {tag, " R6 active"}, 32'(active_o), 32'(ea));
    chk(seal_bank_o == !ea, {tag, " R9 seal target"}, 32'(seal_bank_o), 32'(!ea));
  endtask

  task automatic seal_check(input logic [31:0] g, input int seed);
    logic [31:0] eg = g + 1, ea_dl;
    logic [7:0]  eck;
    logic [1:0]  ok_b = bank_ok_o;
    logic        act_b = active_o;
    logic [31:0] g0_b = gen0_o;
    build(0, g, seed, 0);
    mem[0] = 8'h00;
    eck = calc_ck(0, 8'h5A);
    put32(24, eg);
    ea_dl = calc_adl(0);
    put32(24, g);
    run_op(1'b1, 1'b0, IMG);
    chk(seal_gen_o == eg, "R8 seal generation", seal_gen_o, eg);
    chk(seal_cksum_o == eck, "R8 seal header sum", 32'(seal_cksum_o), 32'(eck));
    chk(seal_adler_o == ea_dl, "R8 seal body checksum", seal_adler_o, ea_dl);
    chk(bank_ok_o == ok_b && active_o == act_b && gen0_o == g0_b, "R8 scan results untouched",
        {active_o, bank_ok_o}, {act_b, ok_b});
    chk(seal_bank_o == !act_b, "R9 seal target after seal", 32'(seal_bank_o), 32'(!act_b));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] gl [4];
    gl[0] = 32'd0; gl[1] = 32'd1; gl[2] = 32'h100; gl[3] = 32'hFFFF_FFFF;
    for (int i = 0; i < 2 * IMG; i++) mem[i] = 8'hFF;
    repeat (4) @(negedge clk_i);
    // R7 reset state
    chk(!busy_o && !done_o && !ready_o, "R7 reset control", {busy_o, done_o, ready_o}, 0);
    chk(bank_ok_o == 0 && gen0_o == 0 && gen1_o == 0 && !active_o, "R7 reset results",
        gen0_o | gen1_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // erased flash: both banks invalid
    scan_check(1'b0, 1'b0, 0, 0, 1'b0, "erased");

    // generation sweep, both banks valid (R5 R6)
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        build(0, gl[a], 3 + a, 0);
        build(1, gl[b], 11 + b, 0);
        scan_check(1'b1, 1'b1, gl[a], gl[b], 1'b0, "gen sweep");
      end

    // fault sweep per bank (R2 R3 R4)
    for (int d0 = 0; d0 < 4; d0++)
      for (int d1 = 0; d1 < 4; d1++) begin
        build(0, 32'd3, 5, d0);
        build(1, 32'd7, 9, d1);
        scan_check(d0 == 0, d1 == 0, 32'd3, 32'd7, 1'b0, "fault sweep");
      end

    // all-0xFF body: low sum wraps the modulus (R4)
    build(0, 32'd2, 0, 0);
    build(1, 32'd1, 0, 0);
    scan_check(1'b1, 1'b1, 32'd2, 32'd1, 1'b0, "wrap body");

    // R10: start pulse mid-scan
    build(0, 32'd4, 7, 0);
    build(1, 32'd9, 13, 0);
    scan_check(1'b1, 1'b1, 32'd4, 32'd9, 1'b1, "busy start");

    // R8 R9 seal with carries across bytes
    seal_check(32'h0000_00FF, 21);
    seal_check(32'hFFFF_FFFF, 0);
    seal_check(32'h1234_5678, 17);

    // rescan after seals flips target (R9)
    build(0, 32'd9, 7, 0);
    build(1, 32'd4, 13, 0);
    scan_check(1'b1, 1'b1, 32'd9, 32'd4, 1'b0, "rescan");
    seal_check(32'd9, 6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule